// File: doc/BRIEF.md
# Gated Decimal Pulse Scaler

This block counts clean logic-level pulses from a detector front end during a gate window of known length. A start command loads a seven-digit decimal down-counter with a preset built from two settings: a decade code that picks the power of ten, and a two-bit multiplier that picks a leading digit of 1, 2, 4 or 8. While the gate is open, the timer steps down by one on each cycle that carries the reference tick. A seven-digit decimal up-counter adds one for each rising edge of the pulse input.

The pulse input is asynchronous. It is brought into the system clock domain through a two-flop synchroniser, and an edge detector turns each rising edge into a single one-cycle increment. A long pulse therefore counts once, and a train of narrow pulses counts each pulse, as long as every high and low phase lasts at least one clock. When the timer reaches zero, the gate closes and a one-cycle done flag is raised. The count then holds until a clear or a new start.

Top module: `bcd_pulse_scaler`

## Requirements
- R1: After a synchronous reset, the count is zero and the gate, done and overflow outputs are all low.
- R2: A start received while the gate is closed opens the gate on the next clock. In the same clock it zeroes the count and the overflow flag.
- R3: The gate stays open for exactly M × 10^d reference ticks. M is 1, 2, 4 or 8 for mult_sel codes 0, 1, 2 and 3. d is the range_sel code 0 to 5. Codes 6 and 7 act as 5, and d never exceeds DIGITS−1.
- R4: The done output is high for exactly one clock. It goes high in the same clock that the gate falls, and that clock directly follows the tick that brings the timer to zero.
- R5: Each rising edge on pulse_in adds exactly one to the count, whatever the pulse width. The new count appears two clocks after the first clock edge that samples the input high.
- R6: Edges are counted only while the gate is open. An edge whose increment would fall in the clock of the terminal tick is not counted.
- R7: The count is packed decimal, with digit i in bits [4i+3:4i]. Each digit runs 0 to 9 and carries into the next digit, so 9 is followed by 10 (0x10).
- R8: When the count steps past all nines, it wraps to zero and sets overflow. Overflow then stays high until a clear or an accepted start.
- R9: A start that arrives while the gate is open is ignored. The timer keeps running, the gate length does not change and the count is not zeroed.
- R10: Clear zeroes the count and the overflow flag at any time and takes precedence over an increment in the same clock. It does not change the gate or the timer.
- R11: The timer changes only in clocks where tick is high. With no ticks, the gate stays open indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous shaped detector pulse |
| tick | input | 1 | One-clock reference time-base strobe |
| start | input | 1 | Load the timer and open the gate |
| clear | input | 1 | Zero the count and the overflow flag |
| range_sel | input | 3 | Decade code for the timer preset |
| mult_sel | input | 2 | Multiplier code (×1, ×2, ×4, ×8) |
| count_bcd | output | 4*DIGITS | Packed decimal pulse count |
| gate_active | output | 1 | Gate window open |
| done | output | 1 | One-clock gate-end strobe |
| overflow | output | 1 | Sticky count wrap flag |

## Verification
Pulses are driven in four patterns. Short pulses at the highest rate check the synchroniser latency and the carry between digits. Pulses longer than a thousand clocks must each count exactly once, which separates edge detection from level counting. A dense train that runs past the end of the gate exercises the terminal-cycle exclusion and the closed-gate hold. A second instance with two digits is driven past 99 to show the wrap and the sticky overflow. Stopping the ticks, holding tick high, and using an out-of-range decade code check the gate length, the clamping of the decade code, and that the timer is paced by the tick.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int DIGIT_W   = 4;
    localparam int TOP_DECADE = 5;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef enum logic [1:0] {
        MULT_X1 = 2'd0,
        MULT_X2 = 2'd1,
        MULT_X4 = 2'd2,
        MULT_X8 = 2'd3
    } mult_e;

    typedef struct packed {
        logic open;
        logic accept;
        logic closing;
        logic done;
    } gate_stat_t;

    function automatic bcd_digit_t mult_digit(input mult_e m);
        case (m)
            MULT_X1: return 4'd1;
            MULT_X2: return 4'd2;
            MULT_X4: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic bcd_digit_t digit_up(input bcd_digit_t d);
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

    function automatic bcd_digit_t digit_down(input bcd_digit_t d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    genvar i;
    generate
        for (i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/gate_timer.sv
module gate_timer
    import scaler_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       tick,
    input  logic [2:0] range_sel,
    input  logic [1:0] mult_sel,
    output gate_stat_t stat
);
    localparam int MAX_DEC = (TOP_DECADE < DIGITS - 1) ? TOP_DECADE : DIGITS - 1;

    bcd_digit_t [DIGITS-1:0] timer_q, timer_dec, preset;
    logic [DIGITS:0] borrow;
    logic [DIGITS:0] upper_zero;
    logic            gate_q, done_q, is_one, accept, closing;
    int unsigned     dec_idx;

    always_comb begin
        if (int'(range_sel) > MAX_DEC) dec_idx = MAX_DEC;
        else                           dec_idx = int'(range_sel);
    end

    assign borrow[0]          = 1'b1;
    assign upper_zero[DIGITS] = 1'b1;

    genvar i;
    generate
        for (i = 0; i < DIGITS; i++) begin : g_digit
            assign preset[i]     = (dec_idx == i) ? mult_digit(mult_e'(mult_sel)) : 4'd0;
            assign timer_dec[i]  = borrow[i] ? digit_down(timer_q[i]) : timer_q[i];
            assign borrow[i+1]   = borrow[i] & (timer_q[i] == 4'd0);
            assign upper_zero[i] = upper_zero[i+1] & ((i == 0) || (timer_q[i] == 4'd0));
        end
    endgenerate

    assign is_one  = upper_zero[0] & (timer_q[0] == 4'd1);
    assign accept  = start & ~gate_q;
    assign closing = gate_q & tick & is_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            gate_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= closing;
            if (accept) begin
                timer_q <= preset;
                gate_q  <= 1'b1;
            end else if (gate_q && tick) begin
                timer_q <= timer_dec;
                if (is_one) gate_q <= 1'b0;
            end
        end
    end

    assign stat.open    = gate_q;
    assign stat.accept  = accept;
    assign stat.closing = closing;
    assign stat.done    = done_q;

    a_r2_gate_opens: assert property (@(posedge clk) disable iff (rst)
        (start && !gate_q) |=> gate_q);
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_q) |-> done_q);
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (gate_q && start && !closing) |=> gate_q);
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (gate_q && !tick) |=> (gate_q && $stable(timer_q)));

endmodule

// File: rtl/bcd_accum.sv
module bcd_accum
    import scaler_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   count,
    output logic                  ovf
);
    bcd_digit_t [DIGITS-1:0] cnt_q, cnt_nxt;
    logic [DIGITS:0]         carry;
    logic                    ovf_q;

    assign carry[0] = inc;

    genvar i;
    generate
        for (i = 0; i < DIGITS; i++) begin : g_digit
            assign cnt_nxt[i]  = carry[i] ? digit_up(cnt_q[i]) : cnt_q[i];
            assign carry[i+1]  = carry[i] & (cnt_q[i] == 4'd9);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (carry[DIGITS]) ovf_q <= 1'b1;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr) |=> ovf_q);
    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && !ovf_q));
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd_pulse_scaler.sv
module bcd_pulse_scaler
    import scaler_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse_in,
    input  logic                tick,
    input  logic                start,
    input  logic                clear,
    input  logic [2:0]          range_sel,
    input  logic [1:0]          mult_sel,
    output logic [4*DIGITS-1:0] count_bcd,
    output logic                gate_active,
    output logic                done,
    output logic                overflow
);
    logic       rise, inc, clr_all;
    gate_stat_t gs;

    edge_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pulse_in),
        .rise     (rise)
    );

    gate_timer #(.DIGITS(DIGITS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tick      (tick),
        .range_sel (range_sel),
        .mult_sel  (mult_sel),
        .stat      (gs)
    );

    assign inc     = rise & gs.open & ~gs.closing;
    assign clr_all = clear | gs.accept;

    bcd_accum #(.DIGITS(DIGITS)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_all),
        .inc   (inc),
        .count (count_bcd),
        .ovf   (overflow)
    );

    assign gate_active = gs.open;
    assign done        = gs.done;

    a_r6_closed_gate_holds: assert property (@(posedge clk) disable iff (rst)
        (!gate_active && !clear && !start) |=> $stable(count_bcd));
    a_r10_clear_keeps_gate: assert property (@(posedge clk) disable iff (rst)
        (clear && gate_active && !tick) |=> gate_active);

endmodule

// File: tb/bcd_pulse_scaler_bench.sv
module bcd_pulse_scaler_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_in = 1'b0, tick = 1'b0, start = 1'b0, clear = 1'b0;
    logic [2:0] range_sel = 3'd0;
    logic [1:0] mult_sel  = 2'd0;
    logic [27:0] count_bcd;
    logic [7:0]  s_count;
    logic gate_active, done, overflow, s_gate, s_done, s_ovf;

    always #2.5 clk = ~clk;

    bcd_pulse_scaler #(.DIGITS(7)) u_bcd_pulse_scaler (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .tick(tick), .start(start),
        .clear(clear), .range_sel(range_sel), .mult_sel(mult_sel),
        .count_bcd(count_bcd), .gate_active(gate_active), .done(done), .overflow(overflow));

    bcd_pulse_scaler #(.DIGITS(2)) u_small (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .tick(tick), .start(start),
        .clear(clear), .range_sel(range_sel), .mult_sel(mult_sel),
        .count_bcd(s_count), .gate_active(s_gate), .done(s_done), .overflow(s_ovf));

    int checks = 0, fails = 0;
    int tick_mode = 0;
    int tick_cnt = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state, index 0 = seven digits, 1 = two digits
    longint m_cnt[2];
    longint m_timer[2];
    bit     m_gate[2], m_done[2], m_ov[2];
    bit     h1, h2, h3;
    int     mod_of[2]   = '{10000000, 100};
    int     maxdec_of[2] = '{5, 1};

    function automatic logic [31:0] to_bcd(input longint v);
        logic [31:0] r = '0;
        longint x = v;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic longint preset_ticks(input int k, input logic [2:0] rs, input logic [1:0] ms);
        int d = (int'(rs) > maxdec_of[k]) ? maxdec_of[k] : int'(rs);
        longint v = longint'(1) << ms;
        for (int i = 0; i < d; i++) v = v * 10;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (tick_mode == 1) begin
            tick     <= (tick_cnt == 9);
            tick_cnt <= (tick_cnt == 9) ? 0 : tick_cnt + 1;
        end else begin
            tick <= (tick_mode == 2);
        end
    end

    always @(posedge clk) begin
        bit edge_now, acc, cl, g_old;
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_timer[k] = 0; m_gate[k] = 0; m_done[k] = 0; m_ov[k] = 0;
            end
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            edge_now = h2 && !h3;
            h3 = h2; h2 = h1; h1 = pulse_in;
            for (int k = 0; k < 2; k++) begin
                g_old = m_gate[k];
                acc = start && !g_old;
                cl  = g_old && tick && (m_timer[k] == 1);
                m_done[k] = cl;
                if (acc) begin
                    m_timer[k] = preset_ticks(k, range_sel, mult_sel);
                    m_gate[k]  = 1;
                end else if (g_old && tick) begin
                    m_timer[k] = m_timer[k] - 1;
                    if (m_timer[k] == 0) m_gate[k] = 0;
                end
                if (clear || acc) begin
                    m_cnt[k] = 0; m_ov[k] = 0;
                end else if (edge_now && g_old && !cl) begin
                    m_cnt[k] = m_cnt[k] + 1;
                    if (m_cnt[k] == mod_of[k]) begin
                        m_cnt[k] = 0; m_ov[k] = 1;
                    end
                end
            end
        end
    end

    // cycle compare against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [31:0] e0, e1;
            e0 = to_bcd(m_cnt[0]);
            e1 = to_bcd(m_cnt[1]);
            check("R5 R7 count", count_bcd, e0[27:0]);
            check("R3 gate", gate_active, m_gate[0]);
            check("R4 done", done, m_done[0]);
            check("R8 overflow", overflow, m_ov[0]);
            check("R5 small count", s_count, e1[7:0]);
            check("R3 small gate", s_gate, m_gate[1]);
            check("R4 small done", s_done, m_done[1]);
            check("R8 small overflow", s_ovf, m_ov[1]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int width, input int gap);
        @(negedge clk); pulse_in = 1'b1;
        wait_cycles(width);
        pulse_in = 1'b0;
        wait_cycles(gap);
    endtask

    task automatic do_start(input logic [2:0] rs, input logic [1:0] ms);
        @(negedge clk); range_sel = rs; mult_sel = ms; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_gate_end;
        while (gate_active) @(negedge clk);
    endtask

    initial begin
        int gate_len;
        wait_cycles(5);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        check("R1 count", count_bcd, 0);
        check("R1 gate", gate_active, 0);
        check("R1 done", done, 0);
        check("R1 overflow", overflow, 0);

        // short pulses at the top rate, range 2 x2
        tick_mode = 1;
        do_start(3'd2, 2'd1);
        check("R2 gate opened", gate_active, 1);
        check("R2 count zeroed", count_bcd, 0);
        for (int i = 0; i < 12; i++) pulse(20, 80);
        wait_cycles(4);
        check("R7 decimal carry twelve", count_bcd, 28'h12);
        wait_gate_end();
        check("R6 gate closed", gate_active, 0);
        for (int i = 0; i < 3; i++) pulse(20, 20);
        wait_cycles(4);
        check("R6 no count while closed", count_bcd, 28'h12);

        // long pulses, range 2 x8, with an ignored start
        do_start(3'd2, 2'd3);
        pulse(3000, 200);
        check("R5 long pulse once", count_bcd, 28'h1);
        do_start(3'd0, 2'd0);
        check("R9 count kept", count_bcd, 28'h1);
        check("R9 gate kept", gate_active, 1);
        pulse(3000, 200);
        check("R5 second long pulse", count_bcd, 28'h2);
        wait_gate_end();
        check("R9 full gate ran", count_bcd, 28'h2);

        // no ticks: gate holds, clear mid gate
        tick_mode = 0;
        do_start(3'd0, 2'd0);
        pulse(5, 5);
        pulse(5, 5);
        wait_cycles(300);
        check("R11 gate held without ticks", gate_active, 1);
        check("R11 counted pulses", count_bcd, 28'h2);
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check("R10 clear zeroes count", count_bcd, 0);
        check("R10 gate unaffected", gate_active, 1);
        tick_mode = 1;
        wait_gate_end();

        // dense train past the gate end, small instance overflows
        do_start(3'd1, 2'd3);
        while (gate_active) pulse(3, 3);
        wait_cycles(6);
        check("R8 small overflow set", s_ovf, 1);
        wait_cycles(20);
        check("R8 overflow sticky", s_ovf, 1);
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check("R10 clears overflow", s_ovf, 0);
        check("R10 clears small count", s_count, 0);

        // clamped decade with a tick every clock
        tick_mode = 2;
        do_start(3'd7, 2'd0);
        gate_len = 1;
        while (gate_active) begin
            @(negedge clk);
            if (gate_active) gate_len++;
        end
        check("R3 clamped gate length", gate_len, 100000);
        tick_mode = 0;
        wait_cycles(5);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule